// File: doc/BRIEF.md
# USB Compliance Test Mode Controller

This block holds the 8-bit control register that firmware writes after it accepts a request to enter a USB 2.0 compliance test. It turns the register contents into the behaviour that the rest of the controller and the transceiver need. That behaviour is a forced line-state request, a NAK reply to IN tokens, a forced host role tied to the session flag, a speed choice applied at bus reset, a sequencer that replays a preloaded packet from the endpoint-0 buffer, and a one-shot loopback copy from the endpoint-0 transmit buffer to its receive buffer.

The register is written through a simple write strobe and is always visible on a read-data bus. The packet-replay and loopback sequencers only produce addresses and strobes. The buffers, the transceiver, NRZI, bit stuffing and CRC lie outside the block. The endpoint-0 buffers are assumed to have a combinational read port, so each byte can move in a single clock.

Top module: `usb_testmode_ctrl`

## Requirements
- R1: After reset every register field is 0. `reg_rdata` reads 8'h00, `line_req` is 2'b00, `speed_sel` is 2'b00, and `host_mode`, `nak_req`, `pkt_rd` and `lb_busy` are all low.
- R2: A write stores bits 7 and 5..0, and `reg_rdata` shows them from the next clock. Bit 6 (loopback trigger) always reads back as 0.
- R3: Only one test mode is active at a time. The priority from highest to lowest is bit 3 (packet replay), bit 2 (K), bit 1 (J), bit 0 (SE0/NAK). `line_req` is 2'b10 in K mode, 2'b01 in J mode and 2'b00 otherwise, and it never reads 2'b11.
- R4: In SE0/NAK mode, `speed_sel` reads 2'b10. Each cycle in which `in_token_valid` is high produces a one-cycle `nak_req` pulse on the next cycle. Outside that mode, `nak_req` stays low.
- R5: With bit 7 (forced host) set, `host_mode` rises on the clock after `session` is high, whether or not a device is attached.
- R6: Once `host_mode` is high it stays high while `session` is high, even if bit 7 is cleared. It drops on the clock after `session` goes low. If bit 7 is set, it is entered again on the next session.
- R7: The speed is latched on `bus_reset` and on entry to host mode. The value is 2'b10 (high) if bit 4 is set, otherwise 2'b01 (full) if bit 5 is set, otherwise 2'b00. High speed wins when both bits are set.
- R8: In packet-replay mode, `pkt_addr` steps 0..52 with `pkt_rd` high. `pkt_sop` is high at address 0 and `pkt_eop` at address 52. This is followed by `GAP_CYCLES` (default 4) cycles with `pkt_rd` low, and then the sequence repeats.
- R9: When the replay mode is left, `pkt_rd` and `line_req` are idle from the next clock. The partly sent packet is dropped, and the next entry starts again at address 0.
- R10: Writing 1 to bit 6 while idle, with `lb_len` = N > 0, raises `lb_busy`, `lb_rd` and `lb_wr` for exactly N cycles. During those cycles `lb_addr` runs 0..N-1, and bit 6 then clears itself.
- R11: A write of 1 to bit 6 while `lb_busy` is high does not restart or lengthen the copy. A trigger with `lb_len` = 0 starts no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| session | input | 1 | Session active flag |
| bus_reset | input | 1 | USB bus reset detected |
| in_token_valid | input | 1 | Valid IN token received (one cycle) |
| line_req | output | 2 | Forced line state: 00 none, 01 J, 10 K |
| nak_req | output | 1 | Request a NAK handshake |
| host_mode | output | 1 | Controller acts as host |
| speed_sel | output | 2 | Forced speed: 00 none, 01 full, 10 high |
| pkt_rd | output | 1 | Replay read strobe to endpoint-0 buffer |
| pkt_addr | output | 6 | Replay byte address |
| pkt_sop | output | 1 | First byte of a replayed packet |
| pkt_eop | output | 1 | Last byte of a replayed packet |
| lb_len | input | 7 | Byte count held in endpoint-0 transmit buffer |
| lb_busy | output | 1 | Loopback copy in progress |
| lb_rd | output | 1 | Read strobe to endpoint-0 transmit buffer |
| lb_wr | output | 1 | Write strobe to endpoint-0 receive buffer |
| lb_addr | output | 7 | Byte address for both buffers |

## Verification
A wrong mode decode shows up on `line_req` or `pkt_rd` on the first clock after the write that caused it. A replay counter that slips shows up as a wrong address, a misplaced start or end strobe, or a gap of the wrong length within one 57-cycle period. A host-mode state that is off shows up one clock after a `session` change. A loopback counter that is off shows as `lb_busy` lasting the wrong number of cycles or as `lb_addr` skipping a value, all visible within the length of one copy.

// File: rtl/usb_tm_pkg.sv
// Shared types and field positions for the USB test mode controller.
// Assumes: the control register is 8 bits and the fields sit at fixed bits.
package usb_tm_pkg;
    typedef enum logic [1:0] {LS_NONE = 2'b00, LS_J = 2'b01, LS_K = 2'b10} line_t;
    typedef enum logic [2:0] {TM_OFF, TM_SE0NAK, TM_J, TM_K, TM_PKT} tmode_t;
    typedef enum logic [1:0] {SPD_AUTO = 2'b00, SPD_FS = 2'b01, SPD_HS = 2'b10} speed_t;

    localparam int B_HOST = 7;
    localparam int B_LOOP = 6;
    localparam int B_FS   = 5;
    localparam int B_HS   = 4;
    localparam int B_PKT  = 3;
    localparam int B_K    = 2;
    localparam int B_J    = 1;
    localparam int B_NAK  = 0;

    // High speed wins over full speed when both are requested.
    function automatic speed_t pick_speed(input logic hs, input logic fs);
        if (hs)      return SPD_HS;
        else if (fs) return SPD_FS;
        else         return SPD_AUTO;
    endfunction
endpackage

// File: rtl/tm_regfile.sv
// Control register with a priority decode of the test-mode bits.
// Assumes: bit 6 is a trigger only. It is never stored and reads back as 0.
module tm_regfile
    import usb_tm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       lb_busy,
    output logic [7:0] rdata,
    output logic [7:0] ctrl,
    output logic       lb_start,
    output tmode_t     mode
);
    logic [7:0] ctrl_q;

    // Store the writable fields. The trigger bit is masked out.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= 8'h00;
        else if (wr_en) ctrl_q <= wdata & ~(8'h01 << B_LOOP);
    end

    // Start a loopback only when no copy is running.
    assign lb_start = wr_en && wdata[B_LOOP] && !lb_busy;
    assign rdata    = ctrl_q;
    assign ctrl     = ctrl_q;

    // Pick one active test mode by fixed priority.
    always_comb begin
        if (ctrl_q[B_PKT])      mode = TM_PKT;
        else if (ctrl_q[B_K])   mode = TM_K;
        else if (ctrl_q[B_J])   mode = TM_J;
        else if (ctrl_q[B_NAK]) mode = TM_SE0NAK;
        else                    mode = TM_OFF;
    end
endmodule

// File: rtl/tm_host_ctrl.sv
// Sticky forced-host state and the speed latched at bus reset or host entry.
// Assumes: session is synchronous to clk.
module tm_host_ctrl
    import usb_tm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   session,
    input  logic   bus_reset,
    input  logic   force_host,
    input  logic   force_hs,
    input  logic   force_fs,
    input  logic   se0nak_mode,
    output logic   host_mode,
    output speed_t speed_sel
);
    logic   host_q;
    speed_t speed_q;
    logic   entering;

    assign entering = session && force_host && !host_q;

    // Host role holds for the whole session once entered.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_q <= 1'b0;
        else if (!session) host_q <= 1'b0;
        else if (entering) host_q <= 1'b1;
    end

    // Capture the forced speed at bus reset or on host entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     speed_q <= SPD_AUTO;
        else if (bus_reset || entering) speed_q <= pick_speed(force_hs, force_fs);
    end

    assign host_mode = host_q;
    assign speed_sel = se0nak_mode ? SPD_HS : speed_q;
endmodule

// File: rtl/tm_pkt_replay.sv
// Address sequencer that replays a preloaded packet with idle gaps between copies.
// Assumes: the packet already sits in the endpoint-0 buffer at addresses 0..PKT_LEN-1.
module tm_pkt_replay #(
    parameter int PKT_LEN    = 53,
    parameter int GAP_CYCLES = 4,
    localparam int AW  = $clog2(PKT_LEN),
    localparam int GW  = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output logic          pkt_rd,
    output logic [AW-1:0] pkt_addr,
    output logic          pkt_sop,
    output logic          pkt_eop
);
    localparam logic [AW-1:0] LAST     = AW'(PKT_LEN - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    logic          in_gap_q;
    logic [AW-1:0] cnt_q;
    logic [GW-1:0] gap_q;

    // Step through the packet bytes and then the gap. Restart when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            in_gap_q <= 1'b0;
            cnt_q    <= '0;
            gap_q    <= '0;
        end else if (!in_gap_q) begin
            if (cnt_q == LAST) begin
                cnt_q    <= '0;
                in_gap_q <= 1'b1;
                gap_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (gap_q == GAP_LAST) in_gap_q <= 1'b0;
            else                   gap_q    <= gap_q + 1'b1;
        end
    end

    assign pkt_rd   = enable && !in_gap_q;
    assign pkt_addr = cnt_q;
    assign pkt_sop  = pkt_rd && (cnt_q == '0);
    assign pkt_eop  = pkt_rd && (cnt_q == LAST);
endmodule

// File: rtl/tm_loopback.sv
// One-shot copy from the EP0 transmit buffer to the EP0 receive buffer, one byte per clock.
// Assumes: both buffers share the address and the transmit buffer reads combinationally.
module tm_loopback #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] len,
    output logic          busy,
    output logic          rd,
    output logic          wr,
    output logic [AW-1:0] addr
);
    logic          busy_q;
    logic [AW-1:0] idx_q;
    logic [AW-1:0] last_q;

    // Run the byte index from 0 to len-1 and then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (busy_q) begin
            if (idx_q == last_q) busy_q <= 1'b0;
            else                 idx_q  <= idx_q + 1'b1;
        end else if (start && len != '0) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= len - 1'b1;
        end
    end

    assign busy = busy_q;
    assign rd   = busy_q;
    assign wr   = busy_q;
    assign addr = idx_q;
endmodule

// File: rtl/usb_testmode_ctrl.sv
// Top of the USB compliance test mode controller: register, host/speed control,
// packet replay and EP0 loopback.
// Assumes: all inputs are synchronous to clk.
module usb_testmode_ctrl
    import usb_tm_pkg::*;
#(
    parameter int PKT_LEN    = 53,
    parameter int GAP_CYCLES = 4,
    parameter int LB_AW      = 7,
    localparam int PKT_AW    = $clog2(PKT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              session,
    input  logic              bus_reset,
    input  logic              in_token_valid,
    output logic [1:0]        line_req,
    output logic              nak_req,
    output logic              host_mode,
    output logic [1:0]        speed_sel,
    output logic              pkt_rd,
    output logic [PKT_AW-1:0] pkt_addr,
    output logic              pkt_sop,
    output logic              pkt_eop,
    input  logic [LB_AW-1:0]  lb_len,
    output logic              lb_busy,
    output logic              lb_rd,
    output logic              lb_wr,
    output logic [LB_AW-1:0]  lb_addr
);
    logic [7:0] ctrl;
    logic       lb_start;
    tmode_t     mode;
    speed_t     spd;
    logic       nak_q;

    tm_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
        .lb_busy(lb_busy), .rdata(reg_rdata), .ctrl(ctrl),
        .lb_start(lb_start), .mode(mode)
    );

    tm_host_ctrl u_host (
        .clk(clk), .rst_n(rst_n), .session(session), .bus_reset(bus_reset),
        .force_host(ctrl[B_HOST]), .force_hs(ctrl[B_HS]), .force_fs(ctrl[B_FS]),
        .se0nak_mode(mode == TM_SE0NAK), .host_mode(host_mode), .speed_sel(spd)
    );

    tm_pkt_replay #(.PKT_LEN(PKT_LEN), .GAP_CYCLES(GAP_CYCLES)) u_replay (
        .clk(clk), .rst_n(rst_n), .enable(mode == TM_PKT),
        .pkt_rd(pkt_rd), .pkt_addr(pkt_addr), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop)
    );

    tm_loopback #(.AW(LB_AW)) u_loop (
        .clk(clk), .rst_n(rst_n), .start(lb_start), .len(lb_len),
        .busy(lb_busy), .rd(lb_rd), .wr(lb_wr), .addr(lb_addr)
    );

    // Answer each valid IN token with a NAK on the next cycle in SE0/NAK mode.
    always_ff @(posedge clk) begin
        if (!rst_n) nak_q <= 1'b0;
        else        nak_q <= in_token_valid && (mode == TM_SE0NAK);
    end

    // Drive the forced line state from the active mode.
    always_comb begin
        unique case (mode)
            TM_K:    line_req = LS_K;
            TM_J:    line_req = LS_J;
            default: line_req = LS_NONE;
        endcase
    end

    assign nak_req   = nak_q;
    assign speed_sel = spd;
endmodule

// File: rtl/tm_checker.sv
// Protocol checks on the ports of usb_testmode_ctrl, attached with bind.
// Assumes: default parameter widths (6-bit replay address, 7-bit loopback address).
module tm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       session,
    input logic       in_token_valid,
    input logic [1:0] line_req,
    input logic       nak_req,
    input logic       host_mode,
    input logic       pkt_rd,
    input logic [5:0] pkt_addr,
    input logic       pkt_sop,
    input logic       pkt_eop,
    input logic       lb_busy,
    input logic       lb_rd,
    input logic       lb_wr,
    input logic [6:0] lb_addr
);
    // The forced line state uses only the three legal codes.
    assert_line_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_req != 2'b11);

    // A NAK request only ever follows a valid IN token.
    assert_nak_after_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |-> $past(in_token_valid));

    // The host role ends once the session is gone.
    assert_host_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !session |=> !host_mode);

    // The host role holds while the session stays up.
    assert_host_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && session) |=> host_mode);

    // The start strobe marks byte 0 of a read.
    assert_sop_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sop |-> (pkt_rd && pkt_addr == 6'd0));

    // The last byte is followed by an idle gap.
    assert_gap_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_eop |=> !pkt_rd);

    // Buffer strobes move only during a copy.
    assert_lb_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd || lb_wr) |-> lb_busy);

    // Within one copy the address advances by one per clock.
    assert_lb_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_busy && $past(lb_busy)) |-> (lb_addr == $past(lb_addr) + 7'd1));
endmodule

bind usb_testmode_ctrl tm_checker u_tm_checker (
    .clk(clk), .rst_n(rst_n), .session(session), .in_token_valid(in_token_valid),
    .line_req(line_req), .nak_req(nak_req), .host_mode(host_mode),
    .pkt_rd(pkt_rd), .pkt_addr(pkt_addr), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .lb_busy(lb_busy), .lb_rd(lb_rd), .lb_wr(lb_wr), .lb_addr(lb_addr)
);

// File: tb/test_usb_testmode_ctrl.sv
// Self-checking bench: a vector table for register/mode decode, then directed tests.
module test_usb_testmode_ctrl;
    localparam int PKT = 53;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       session = 1'b0;
    logic       bus_reset = 1'b0;
    logic       in_token_valid = 1'b0;
    logic [1:0] line_req;
    logic       nak_req;
    logic       host_mode;
    logic [1:0] speed_sel;
    logic       pkt_rd;
    logic [5:0] pkt_addr;
    logic       pkt_sop;
    logic       pkt_eop;
    logic [6:0] lb_len = 7'd0;
    logic       lb_busy;
    logic       lb_rd;
    logic       lb_wr;
    logic [6:0] lb_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_testmode_ctrl i_usb_testmode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .session(session), .bus_reset(bus_reset),
        .in_token_valid(in_token_valid), .line_req(line_req), .nak_req(nak_req),
        .host_mode(host_mode), .speed_sel(speed_sel), .pkt_rd(pkt_rd),
        .pkt_addr(pkt_addr), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
        .lb_len(lb_len), .lb_busy(lb_busy), .lb_rd(lb_rd), .lb_wr(lb_wr),
        .lb_addr(lb_addr)
    );

    // {write data, expected read data, expected line state}
    localparam logic [17:0] VEC [8] = '{
        {8'h04, 8'h04, 2'b10},
        {8'h02, 8'h02, 2'b01},
        {8'h06, 8'h06, 2'b10},
        {8'h0E, 8'h0E, 2'b00},
        {8'h03, 8'h03, 2'b01},
        {8'h01, 8'h01, 2'b00},
        {8'hB2, 8'hB2, 2'b01},
        {8'h7F, 8'h3F, 2'b00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", 16'(reg_rdata), 16'h00);
        check("R1 line", 16'(line_req), 16'h0);
        check("R1 speed", 16'(speed_sel), 16'h0);
        check("R1 idle outputs", 16'({host_mode, nak_req, pkt_rd, lb_busy}), 16'h0);

        // R2 R3 vector table
        foreach (VEC[i]) begin
            write(VEC[i][17:10]);
            check("R2 readback", 16'(reg_rdata), 16'(VEC[i][9:2]));
            check("R3 line priority", 16'(line_req), 16'(VEC[i][1:0]));
        end
        write(8'h0C);
        check("R3 packet over K", 16'({pkt_rd, line_req}), 16'h4);
        write(8'h00);

        // R4 SE0/NAK
        write(8'h01);
        check("R4 speed high", 16'(speed_sel), 16'h2);
        in_token_valid = 1'b1;
        @(negedge clk);
        in_token_valid = 1'b0;
        check("R4 nak pulse", 16'(nak_req), 16'h1);
        @(negedge clk);
        check("R4 nak one cycle", 16'(nak_req), 16'h0);
        write(8'h00);
        in_token_valid = 1'b1;
        @(negedge clk);
        in_token_valid = 1'b0;
        check("R4 no nak outside mode", 16'(nak_req), 16'h0);

        // R5 R6 forced host
        write(8'h80);
        check("R5 no host without session", 16'(host_mode), 16'h0);
        session = 1'b1;
        @(negedge clk);
        check("R5 host entered", 16'(host_mode), 16'h1);
        write(8'h00);
        @(negedge clk);
        check("R6 host sticky", 16'(host_mode), 16'h1);
        session = 1'b0;
        @(negedge clk);
        check("R6 host dropped", 16'(host_mode), 16'h0);
        session = 1'b1;
        @(negedge clk);
        check("R6 no reentry without force", 16'(host_mode), 16'h0);
        session = 1'b0;
        @(negedge clk);
        write(8'h80);
        session = 1'b1;
        @(negedge clk);
        check("R6 reentry", 16'(host_mode), 16'h1);
        session = 1'b0;
        @(negedge clk);

        // R7 speed latch
        write(8'h20);
        check("R7 no latch before reset", 16'(speed_sel), 16'h0);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        check("R7 full speed", 16'(speed_sel), 16'h1);
        write(8'h30);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        check("R7 high wins", 16'(speed_sel), 16'h2);
        write(8'hA0);
        session = 1'b1;
        @(negedge clk);
        check("R7 latch on host entry", 16'({host_mode, speed_sel}), 16'h5);
        session = 1'b0;
        write(8'h00);

        // R8 packet replay
        write(8'h08);
        for (int k = 0; k <= PKT + GAP; k++) begin
            int p;
            p = k % (PKT + GAP);
            if (p < PKT) begin
                check("R8 replay addr", 16'({pkt_rd, pkt_addr}), 16'({1'b1, 6'(p)}));
                check("R8 sop/eop", 16'({pkt_sop, pkt_eop}),
                      16'({p == 0, p == PKT - 1}));
            end else begin
                check("R8 gap idle", 16'(pkt_rd), 16'h0);
            end
            @(negedge clk);
        end

        // R9 abandon mid packet
        repeat (9) @(negedge clk);
        write(8'h00);
        check("R9 replay stops", 16'({pkt_rd, line_req}), 16'h0);
        write(8'h08);
        check("R9 restart at 0", 16'({pkt_sop, pkt_addr}), 16'h40);
        write(8'h04);
        write(8'h00);
        check("R9 line none after clear", 16'(line_req), 16'h0);

        // R10 loopback copy
        lb_len = 7'd5;
        write(8'h40);
        check("R10 bit6 reads 0", 16'(reg_rdata), 16'h00);
        for (int k = 0; k < 5; k++) begin
            check("R10 copy addr", 16'({lb_busy, lb_rd, lb_wr, lb_addr}),
                  16'({3'b111, 7'(k)}));
            @(negedge clk);
        end
        check("R10 self clear", 16'(lb_busy), 16'h0);

        // R11 retrigger while busy is ignored
        write(8'h40);
        lb_len = 7'd9;
        write(8'h40);
        check("R11 no restart", 16'(lb_addr), 16'h2);
        @(negedge clk);
        @(negedge clk);
        check("R11 last byte", 16'({lb_busy, lb_addr}), 16'({1'b1, 7'd4}));
        @(negedge clk);
        check("R11 ends at original length", 16'(lb_busy), 16'h0);
        lb_len = 7'd0;
        write(8'h40);
        check("R11 zero length", 16'(lb_busy), 16'h0);

        done = 1'b1;
        finish_run();
    end
endmodule